// File: doc/BRIEF.md
# Inter-Processor Doorbell Message Unit

This block lets software on any of N cores raise a doorbell interrupt on other cores. A core issues a send operation carrying a 32-bit operand that names the doorbell kind, a broadcast flag and a target tag. The unit compares the tag with every core's identity value and, for each core that matches, latches a pending bit of the decoded kind. If the broadcast flag is set, every core is targeted whatever the tag holds.

There are two kinds of doorbell, normal and critical, and each core has one pending bit of each kind. A core removes its own pending bit by issuing a clear operation with an operand of the same layout. A clear acts only on the core that issues it, and only on the bit of the kind it names. Operand kinds other than normal and critical are dropped without any effect. Each core's interrupt request line is raised while either of its pending bits is set.

Operand layout: kind field in bits 31:27, broadcast flag in bit 26, tag in bits TAG_W-1:0 (13:0 by default). The remaining bits are ignored.

Top module: `dbell_msg_unit`

## Requirements
- R1: After reset every normal pending bit, every critical pending bit and every interrupt request is 0.
- R2: A send whose kind field (bits 31:27) is 0 sets the normal pending bit of each targeted core. The bit is visible one clock after the send is sampled.
- R3: A send whose kind field is 1 sets the critical pending bit of each targeted core one clock later. The normal pending bits are left alone.
- R4: Without broadcast, a core is targeted exactly when its identity value equals the tag (bits TAG_W-1:0). Every core with that identity is targeted, and no other core is.
- R5: A send with the broadcast flag (bit 26) set targets every core, whatever the tag.
- R6: A send whose kind field is 2 through 31 changes no pending bit, even when broadcast is set.
- R7: A core's interrupt request is 1 exactly when its normal or its critical pending bit is 1.
- R8: A clear of kind 0 or 1 from core i clears only core i's pending bit of that kind one clock later. Core i's other pending bit and all other cores' bits are unchanged.
- R9: A clear whose kind field is 2 through 31 has no effect.
- R10: A send and clears in the same cycle are all applied. Where a set and a clear hit the same bit, the bit ends set.
- R11: A pending bit stays set until a matching clear arrives. Idle cycles and repeated sends do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_id_i | input | N_CORES*TAG_W | Identity value of each core, core i in slice i |
| snd_vld_i | input | 1 | Send operation valid |
| snd_op_i | input | 32 | Send operand |
| clr_vld_i | input | N_CORES | Clear operation valid, one per issuing core |
| clr_op_i | input | N_CORES*32 | Clear operand of each core, core i in slice i |
| db_pend_o | output | N_CORES | Normal doorbell pending per core |
| crit_pend_o | output | N_CORES | Critical doorbell pending per core |
| irq_o | output | N_CORES | Interrupt request per core |

## Verification
A send and a clear can both land in one cycle, either on different bits or on the same bit of the same core. The bench provokes both cases. In one, a tag send to one core coincides with a clear issued by another core. In the other, a send to cores that include the clearing core coincides with that core's clear of the same kind. The bench then expects the clear to take effect on the untouched core, and the set to win where both meet. Each outcome is judged by sampling the pending outputs one clock after the shared edge.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int OP_W      = 32;
  localparam int KIND_HI   = 31;
  localparam int KIND_LO   = 27;
  localparam int BCAST_BIT = 26;

  typedef enum logic [1:0] {
    DB_NONE = 2'd0,
    DB_NORM = 2'd1,
    DB_CRIT = 2'd2
  } db_kind_e;

  // Kind field decode: only 0 and 1 carry a doorbell.
  function automatic db_kind_e kind_of(logic [KIND_HI-KIND_LO:0] f);
    case (f)
      5'd0:    return DB_NORM;
      5'd1:    return DB_CRIT;
      default: return DB_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dbell_op_decode.sv
module dbell_op_decode
  import dbell_pkg::*;
#(
  parameter int TAG_W = 14
) (
  input  logic [OP_W-1:0]  op_i,
  output db_kind_e         kind_o,
  output logic             bcast_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [BCAST_BIT-1:TAG_W] gap_unused;

  assign kind_o     = kind_of(op_i[KIND_HI:KIND_LO]);
  assign bcast_o    = op_i[BCAST_BIT];
  assign tag_o      = op_i[TAG_W-1:0];
  assign gap_unused = op_i[BCAST_BIT-1:TAG_W];
endmodule

// File: rtl/dbell_target_match.sv
module dbell_target_match #(
  parameter int N_CORES = 4,
  parameter int TAG_W   = 14
) (
  input  logic                     en_i,
  input  logic                     bcast_i,
  input  logic [TAG_W-1:0]         tag_i,
  input  logic [N_CORES*TAG_W-1:0] core_id_i,
  output logic [N_CORES-1:0]       hit_o
);
  for (genvar g = 0; g < N_CORES; g++) begin : g_cmp
    assign hit_o[g] = en_i && (bcast_i || (core_id_i[g*TAG_W +: TAG_W] == tag_i));
  end
endmodule

// File: rtl/dbell_pend_slot.sv
module dbell_pend_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic set_n_i,
  input  logic set_c_i,
  input  logic clr_n_i,
  input  logic clr_c_i,
  output logic pend_n_o,
  output logic pend_c_o
);
  // set dominates clear on the same bit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_n_o <= 1'b0;
      pend_c_o <= 1'b0;
    end else begin
      pend_n_o <= set_n_i | (pend_n_o & ~clr_n_i);
      pend_c_o <= set_c_i | (pend_c_o & ~clr_c_i);
    end
  end
endmodule

// File: rtl/dbell_msg_unit.sv
module dbell_msg_unit
  import dbell_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int TAG_W   = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CORES*TAG_W-1:0] core_id_i,
  input  logic                     snd_vld_i,
  input  logic [OP_W-1:0]          snd_op_i,
  input  logic [N_CORES-1:0]       clr_vld_i,
  input  logic [N_CORES*OP_W-1:0]  clr_op_i,
  output logic [N_CORES-1:0]       db_pend_o,
  output logic [N_CORES-1:0]       crit_pend_o,
  output logic [N_CORES-1:0]       irq_o
);
  db_kind_e             snd_kind_w;
  logic                 bcast_w;
  logic [TAG_W-1:0]     tag_w;
  logic                 snd_ok_w;
  logic [N_CORES-1:0]   hit_w;
  logic [N_CORES-1:0]   set_norm_w;
  logic [N_CORES-1:0]   set_crit_w;
  logic [N_CORES-1:0]   clr_norm_w;
  logic [N_CORES-1:0]   clr_crit_w;

  dbell_op_decode #(.TAG_W(TAG_W)) u_snd_dec (
    .op_i    (snd_op_i),
    .kind_o  (snd_kind_w),
    .bcast_o (bcast_w),
    .tag_o   (tag_w)
  );

  assign snd_ok_w = snd_vld_i && (snd_kind_w != DB_NONE);

  dbell_target_match #(.N_CORES(N_CORES), .TAG_W(TAG_W)) u_match (
    .en_i      (snd_ok_w),
    .bcast_i   (bcast_w),
    .tag_i     (tag_w),
    .core_id_i (core_id_i),
    .hit_o     (hit_w)
  );

  assign set_norm_w = hit_w & {N_CORES{snd_kind_w == DB_NORM}};
  assign set_crit_w = hit_w & {N_CORES{snd_kind_w == DB_CRIT}};

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    db_kind_e           clr_kind_w;
    logic [KIND_LO-1:0] clr_unused_w;

    assign clr_kind_w    = kind_of(clr_op_i[g*OP_W+KIND_LO +: (KIND_HI-KIND_LO+1)]);
    assign clr_unused_w  = clr_op_i[g*OP_W +: KIND_LO];
    assign clr_norm_w[g] = clr_vld_i[g] && (clr_kind_w == DB_NORM);
    assign clr_crit_w[g] = clr_vld_i[g] && (clr_kind_w == DB_CRIT);

    dbell_pend_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_n_i  (set_norm_w[g]),
      .set_c_i  (set_crit_w[g]),
      .clr_n_i  (clr_norm_w[g]),
      .clr_c_i  (clr_crit_w[g]),
      .pend_n_o (db_pend_o[g]),
      .pend_c_o (crit_pend_o[g])
    );
  end

  assign irq_o = db_pend_o | crit_pend_o;
endmodule

// File: rtl/dbell_msg_unit_chk.sv
module dbell_msg_unit_chk #(
  parameter int N_CORES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               snd_vld_i,
  input logic               snd_ok_w,
  input logic               bcast_w,
  input logic [N_CORES-1:0] set_norm_w,
  input logic [N_CORES-1:0] set_crit_w,
  input logic [N_CORES-1:0] clr_norm_w,
  input logic [N_CORES-1:0] clr_crit_w,
  input logic [N_CORES-1:0] db_pend_o,
  input logic [N_CORES-1:0] crit_pend_o
);
  // R2: a normal set is seen on the outputs the next cycle (set beats clear, R10)
  p_norm_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_norm_w) |=> ((db_pend_o & $past(set_norm_w)) == $past(set_norm_w)));

  // R3: a critical set is seen on the outputs the next cycle
  p_crit_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_crit_w) |=> ((crit_pend_o & $past(set_crit_w)) == $past(set_crit_w)));

  // R4: a pending bit rises only where a set was issued
  p_no_stray_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((db_pend_o & ~$past(db_pend_o) & ~$past(set_norm_w)) == '0) &&
              ((crit_pend_o & ~$past(crit_pend_o) & ~$past(set_crit_w)) == '0)));

  // R5: an accepted broadcast reaches every core
  p_bcast_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_ok_w && bcast_w) |=> ((&db_pend_o) || (&crit_pend_o)));

  // R6: an unsupported send produces no set
  p_unsup_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_vld_i && !snd_ok_w) |-> ((set_norm_w == '0) && (set_crit_w == '0)));

  // R8: a pending bit falls only through a clear of that kind
  p_fall_needs_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((~db_pend_o & $past(db_pend_o) & ~$past(clr_norm_w)) == '0) &&
              ((~crit_pend_o & $past(crit_pend_o) & ~$past(clr_crit_w)) == '0)));
endmodule

bind dbell_msg_unit dbell_msg_unit_chk #(.N_CORES(N_CORES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .snd_vld_i   (snd_vld_i),
  .snd_ok_w    (snd_ok_w),
  .bcast_w     (bcast_w),
  .set_norm_w  (set_norm_w),
  .set_crit_w  (set_crit_w),
  .clr_norm_w  (clr_norm_w),
  .clr_crit_w  (clr_crit_w),
  .db_pend_o   (db_pend_o),
  .crit_pend_o (crit_pend_o)
);

// File: tb/dbell_msg_unit_tb.sv
`timescale 1ns/1ps
module dbell_msg_unit_tb_top;
  localparam int N   = 4;
  localparam int TW  = 14;
  localparam int OPW = 32;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [N*TW-1:0]  core_id_i;
  logic             snd_vld_i;
  logic [OPW-1:0]   snd_op_i;
  logic [N-1:0]     clr_vld_i;
  logic [N*OPW-1:0] clr_op_i;
  logic [N-1:0]     db_pend_o, crit_pend_o, irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [N-1:0] exp_n, exp_c;

  always #4 clk = ~clk;

  dbell_msg_unit #(.N_CORES(N), .TAG_W(TW)) dut_i (
    .clk, .rst_n, .core_id_i, .snd_vld_i, .snd_op_i,
    .clr_vld_i, .clr_op_i, .db_pend_o, .crit_pend_o, .irq_o
  );

  // operand: kind 31:27, broadcast 26, tag 13:0
  function automatic logic [31:0] mk_op(logic [4:0] kind, logic bc, logic [13:0] tag);
    return {kind, bc, 12'h000, tag};
  endfunction

  task automatic check_state(string req);
    checks++;
    if (db_pend_o !== exp_n || crit_pend_o !== exp_c || irq_o !== (exp_n | exp_c)) begin
      failures++;
      $display("FAIL %s: norm=%b crit=%b irq=%b expected norm=%b crit=%b irq=%b",
               req, db_pend_o, crit_pend_o, irq_o, exp_n, exp_c, exp_n | exp_c);
    end
  endtask

  task automatic idle_inputs();
    snd_vld_i = 1'b0;
    snd_op_i  = '0;
    clr_vld_i = '0;
    clr_op_i  = '0;
  endtask

  // one cycle of stimulus, then sample one clock later
  task automatic step(logic sv, logic [31:0] sop, logic [N-1:0] cv, logic [N*OPW-1:0] cop);
    @(negedge clk);
    snd_vld_i = sv; snd_op_i = sop; clr_vld_i = cv; clr_op_i = cop;
    @(negedge clk);
    idle_inputs();
  endtask

  function automatic logic [N*OPW-1:0] clr_slot(int core, logic [4:0] kind);
    logic [N*OPW-1:0] v = '0;
    v[core*OPW +: OPW] = mk_op(kind, 1'b0, 14'h0);
    return v;
  endfunction

  task automatic t_reset();
    exp_n = '0; exp_c = '0;
    check_state("R1 reset");
  endtask

  task automatic t_tag_normal();
    step(1'b1, mk_op(5'd0, 1'b0, 14'd5), '0, '0);
    exp_n = 4'b0101;
    check_state("R2 R4 R7 normal send to tag 5");
  endtask

  task automatic t_tag_crit();
    step(1'b1, mk_op(5'd1, 1'b0, 14'd9), '0, '0);
    exp_c = 4'b0010;
    check_state("R3 critical send to tag 9");
  endtask

  task automatic t_nomatch();
    step(1'b1, mk_op(5'd0, 1'b0, 14'd7), '0, '0);
    check_state("R4 tag matches nobody");
  endtask

  task automatic t_bcast();
    step(1'b1, mk_op(5'd1, 1'b1, 14'd7), '0, '0);
    exp_c = 4'b1111;
    check_state("R5 broadcast critical");
  endtask

  task automatic t_unsup_send();
    logic [4:0] kinds [4] = '{5'd2, 5'd3, 5'd4, 5'd31};
    for (int k = 0; k < 4; k++) begin
      step(1'b1, mk_op(kinds[k], 1'b1, 14'd5), '0, '0);
      check_state("R6 unsupported send kind");
    end
  endtask

  task automatic t_clear();
    step(1'b0, '0, 4'b0001, clr_slot(0, 5'd0));
    exp_n[0] = 1'b0;
    check_state("R8 core0 clears normal");
    step(1'b0, '0, 4'b0010, clr_slot(1, 5'd3));
    check_state("R9 unsupported clear kind");
    step(1'b0, '0, 4'b1000, clr_slot(3, 5'd1));
    exp_c[3] = 1'b0;
    check_state("R8 core3 clears critical");
  endtask

  task automatic t_same_cycle();
    // send normal to core3 (tag 3FFF) while core2 clears its normal bit
    step(1'b1, mk_op(5'd0, 1'b0, 14'h3FFF), 4'b0100, clr_slot(2, 5'd0));
    exp_n[3] = 1'b1; exp_n[2] = 1'b0;
    check_state("R10 send and clear on different cores");
    // send normal to tag 5 (cores 0,2) while core2 clears normal: set wins
    step(1'b1, mk_op(5'd0, 1'b0, 14'd5), 4'b0100, clr_slot(2, 5'd0));
    exp_n[0] = 1'b1; exp_n[2] = 1'b1;
    check_state("R10 set wins over clear on same bit");
  endtask

  task automatic t_hold();
    step(1'b1, mk_op(5'd0, 1'b0, 14'd5), '0, '0);
    check_state("R11 repeated send keeps bits");
    repeat (5) @(negedge clk);
    check_state("R11 bits held over idle cycles");
  endtask

  task automatic t_drain();
    logic [N*OPW-1:0] cop = '0;
    for (int c = 0; c < N; c++) cop[c*OPW +: OPW] = mk_op(5'd0, 1'b0, 14'h0);
    step(1'b0, '0, 4'b1111, cop);
    exp_n = '0;
    check_state("R8 R7 all cores clear normal");
    for (int c = 0; c < N; c++) cop[c*OPW +: OPW] = mk_op(5'd1, 1'b0, 14'h0);
    step(1'b0, '0, 4'b1111, cop);
    exp_c = '0;
    check_state("R7 irq low with nothing pending");
  endtask

  initial begin
    core_id_i = {14'h3FFF, 14'd5, 14'd9, 14'd5}; // cores 3,2,1,0
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tag_normal();
    t_tag_crit();
    t_nomatch();
    t_bcast();
    t_unsup_send();
    t_clear();
    t_same_cycle();
    t_hold();
    t_drain();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule